// File: doc/BRIEF.md
# RTC Periodic Interrupt and Update Status Unit

This block is the timing and interrupt core of a real-time clock. It counts a 32.768 kHz reference tick, presented as a one-cycle enable on the system clock, with a divider chain. From that chain it derives a periodic event stream whose rate comes from a 4-bit select code, and it can drive that stream onto a square-wave pin. Once per second it opens an update-in-progress window. It then emits an update-start pulse to the external time counters and closes the window when those counters report completion, or after a fixed limit if they never report.

Three event sources set three sticky flags: periodic, alarm (an external pulse) and update-ended. A summary bit combines each flag with its enable and drives an active-low interrupt line. A single read strobe clears the whole flag byte. An event that arrives in the same cycle as the read is still recorded. A hold input inhibits the once-per-second update so that software can set the time.

Top module: `rtc_pi_core`

## Requirements
- R1: With `rate_sel` equal to 0 no periodic events occur. The periodic flag (bit 6) is not set and `sqw_out` stays low.
- R2: A `rate_sel` code r from 1 to 15 gives one periodic event every 2^(r-1) reference ticks. With `ctl_sqwe` high, `sqw_out` toggles on each event, so its period is 2^r ticks.
- R3: While `ctl_sqwe` is low, `sqw_out` is held low. Periodic events still set the periodic flag.
- R4: A `div_ctl` value of 3'b110 or 3'b111 holds the divider at its half-second point, and 3'b010 lets it run. After a return to 3'b010, the first `upd_start` pulse appears 16384 ticks later.
- R5: `uip` rises 8 ticks before each `upd_start` pulse and stays high through the update.
- R6: `uip` falls on the cycle after `upd_done` is seen during an update, or after 65 ticks of update without `upd_done`. Either ending sets the update-ended flag (bit 4).
- R7: While `ctl_set` is high, no update window opens and no `upd_start` pulse is issued.
- R8: The flag byte carries the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4, with bits 3..0 zero. An `alarm_hit` pulse sets bit 5 on the next cycle.
- R9: Bit 7 of `flags` is high when any of bits 6, 5, 4 is set together with its enable (`ctl_pie`, `ctl_aie`, `ctl_uie`). `irq_n` is the inverse of bit 7.
- R10: A `flag_rd` strobe clears all flag bits, except that an event arriving in the same cycle is kept set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable at the 32.768 kHz reference rate |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| div_ctl | input | 3 | Divider control: 3'b010 run, 3'b110/3'b111 hold in reset |
| ctl_set | input | 1 | Inhibit once-per-second updates |
| ctl_pie | input | 1 | Periodic interrupt enable |
| ctl_aie | input | 1 | Alarm interrupt enable |
| ctl_uie | input | 1 | Update-ended interrupt enable |
| ctl_sqwe | input | 1 | Square-wave output enable |
| alarm_hit | input | 1 | Alarm-match event pulse |
| upd_done | input | 1 | Time counters finished the update |
| flag_rd | input | 1 | Read strobe of the flag byte, clears it |
| sqw_out | output | 1 | Square-wave output |
| irq_n | output | 1 | Active-low interrupt request |
| uip | output | 1 | Update-in-progress status |
| upd_start | output | 1 | One-cycle pulse starting the time-counter update |
| flags | output | 8 | Flag byte: summary, periodic, alarm, update-ended |

## Verification
The assertions assume that `alarm_hit`, `upd_done` and `flag_rd` are single-cycle pulses and that control inputs change only between clock edges. They also assume that `upd_done` is only raised after an `upd_start`. The stimulus changes every input on the falling clock edge and issues each event as a one-cycle pulse. It raises `upd_done` only after observing `upd_start`, and it holds `ref_tick` high so that tick counts equal cycle counts. The timeout path is reached by withholding `upd_done` for a whole update.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;
  // divider control codes (field of the rate/divider register)
  localparam logic [2:0] DIV_RUN   = 3'b010;
  localparam logic [2:0] DIV_HOLDA = 3'b110;
  localparam logic [2:0] DIV_HOLDB = 3'b111;

  // positions in the flag byte
  localparam int FLG_SUM = 7;
  localparam int FLG_PER = 6;
  localparam int FLG_ALM = 5;
  localparam int FLG_UPD = 4;

  typedef enum logic [1:0] {
    UPS_IDLE = 2'd0,
    UPS_PRE  = 2'd1,
    UPS_BUSY = 2'd2
  } upd_state_e;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div
  import rtc_pi_pkg::*;
#(
  parameter int SEC_TICKS = 32768,
  parameter int PRE_TICKS = 8,
  parameter int RATE_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic [2:0]        div_ctl,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              sqwe,
  output logic              run_tick,
  output logic              pre_hit,
  output logic              sec_wrap,
  output logic              per_ev,
  output logic              sqw
);
  localparam int CNT_W = $clog2(SEC_TICKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEC_TICKS - 1);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(SEC_TICKS / 2);
  localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(SEC_TICKS - 1 - PRE_TICKS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] tap_mask;
  logic             sqw_q, sqw_d;
  logic             div_hold, div_run;

  assign div_hold = (div_ctl == DIV_HOLDA) || (div_ctl == DIV_HOLDB);
  assign div_run  = (div_ctl == DIV_RUN);
  assign run_tick = ref_tick && div_run;
  assign sec_wrap = run_tick && (cnt_q == CNT_LAST);
  assign pre_hit  = run_tick && (cnt_q == CNT_PRE);

  // low (rate-1) bits of the chain must all be ones at the event tick
  always_comb begin
    tap_mask = '0;
    for (int i = 0; i < CNT_W; i++) begin
      if (i + 1 < int'(rate_sel)) tap_mask[i] = 1'b1;
    end
  end

  assign per_ev = run_tick && (rate_sel != '0) && ((cnt_q & tap_mask) == tap_mask);

  always_comb begin
    cnt_d = cnt_q;
    if (div_hold) begin
      cnt_d = CNT_HALF;
    end else if (run_tick) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  always_comb begin
    sqw_d = sqw_q;
    if (!sqwe || (rate_sel == '0)) begin
      sqw_d = 1'b0;
    end else if (per_ev) begin
      sqw_d = ~sqw_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_HALF;
      sqw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sqw_q <= sqw_d;
    end
  end

  assign sqw = sqw_q;
endmodule

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq
  import rtc_pi_pkg::*;
#(
  parameter int MAX_TICKS = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_tick,
  input  logic pre_hit,
  input  logic sec_wrap,
  input  logic set_hold,
  input  logic upd_done,
  output logic uip,
  output logic upd_start,
  output logic upd_end
);
  localparam int TMR_W = $clog2(MAX_TICKS + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(MAX_TICKS - 1);

  upd_state_e       st_q, st_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             start_q, start_d;
  logic             uip_q;

  always_comb begin
    st_d    = st_q;
    tmr_d   = tmr_q;
    start_d = 1'b0;
    upd_end = 1'b0;
    unique case (st_q)
      UPS_IDLE: begin
        if (pre_hit && !set_hold) st_d = UPS_PRE;
      end
      UPS_PRE: begin
        if (set_hold) begin
          st_d = UPS_IDLE;
        end else if (sec_wrap) begin
          st_d    = UPS_BUSY;
          tmr_d   = '0;
          start_d = 1'b1;
        end
      end
      UPS_BUSY: begin
        if (set_hold) begin
          st_d = UPS_IDLE;
        end else if (upd_done) begin
          st_d    = UPS_IDLE;
          upd_end = 1'b1;
        end else if (run_tick) begin
          if (tmr_q == TMR_LAST) begin
            st_d    = UPS_IDLE;
            upd_end = 1'b1;
          end else begin
            tmr_d = tmr_q + TMR_W'(1);
          end
        end
      end
      default: st_d = UPS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= UPS_IDLE;
      tmr_q   <= '0;
      start_q <= 1'b0;
      uip_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      tmr_q   <= tmr_d;
      start_q <= start_d;
      uip_q   <= (st_d != UPS_IDLE);
    end
  end

  assign uip       = uip_q;
  assign upd_start = start_q;
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NFLAG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] ev,
  input  logic [NFLAG-1:0] en,
  input  logic             rd,
  output logic [NFLAG-1:0] flg,
  output logic             irq
);
  logic [NFLAG-1:0] flg_q, flg_d;

  // a clearing read loses to an event in the same cycle
  always_comb begin
    flg_d = (rd ? '0 : flg_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flg = flg_q;
  assign irq = |(flg_q & en);
endmodule

// File: rtl/rtc_pi_core.sv
module rtc_pi_core
  import rtc_pi_pkg::*;
#(
  parameter int SEC_TICKS = 32768,
  parameter int PRE_TICKS = 8,
  parameter int UPD_TICKS = 65
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [3:0] rate_sel,
  input  logic [2:0] div_ctl,
  input  logic       ctl_set,
  input  logic       ctl_pie,
  input  logic       ctl_aie,
  input  logic       ctl_uie,
  input  logic       ctl_sqwe,
  input  logic       alarm_hit,
  input  logic       upd_done,
  input  logic       flag_rd,
  output logic       sqw_out,
  output logic       irq_n,
  output logic       uip,
  output logic       upd_start,
  output logic [7:0] flags
);
  logic       run_tick, pre_hit, sec_wrap, per_ev, upd_end, irq;
  logic [2:0] flg;

  rtc_tick_div #(.SEC_TICKS(SEC_TICKS), .PRE_TICKS(PRE_TICKS), .RATE_W(4)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .div_ctl(div_ctl),
    .rate_sel(rate_sel), .sqwe(ctl_sqwe), .run_tick(run_tick),
    .pre_hit(pre_hit), .sec_wrap(sec_wrap), .per_ev(per_ev), .sqw(sqw_out)
  );

  rtc_upd_seq #(.MAX_TICKS(UPD_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_tick(run_tick), .pre_hit(pre_hit),
    .sec_wrap(sec_wrap), .set_hold(ctl_set), .upd_done(upd_done),
    .uip(uip), .upd_start(upd_start), .upd_end(upd_end)
  );

  // flag order inside the unit: [2]=periodic [1]=alarm [0]=update-ended
  rtc_irq_flags #(.NFLAG(3)) u_flg (
    .clk(clk), .rst_n(rst_n),
    .ev({per_ev, alarm_hit, upd_end}),
    .en({ctl_pie, ctl_aie, ctl_uie}),
    .rd(flag_rd), .flg(flg), .irq(irq)
  );

  always_comb begin
    flags          = '0;
    flags[FLG_SUM] = irq;
    flags[FLG_PER] = flg[2];
    flags[FLG_ALM] = flg[1];
    flags[FLG_UPD] = flg[0];
  end

  assign irq_n = ~irq;
endmodule

// File: rtl/rtc_pi_core_chk.sv
module rtc_pi_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rate_sel,
  input logic       ctl_set,
  input logic       ctl_aie,
  input logic       alarm_hit,
  input logic       flag_rd,
  input logic       sqw_out,
  input logic       irq_n,
  input logic       uip,
  input logic       upd_start,
  input logic [7:0] flags
);
  assert_rate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !sqw_out);

  assert_start_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd_start |-> uip);

  assert_end_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(uip) && !$past(ctl_set)) |-> flags[4]);

  assert_hold_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_set |=> !upd_start);

  assert_alarm_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |=> flags[5]);

  assert_alarm_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[5] && ctl_aie) |-> !irq_n);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !alarm_hit) |=> !flags[5]);
endmodule

bind rtc_pi_core rtc_pi_core_chk u_chk (.*);

// File: tb/sim_rtc_pi_core.sv
`timescale 1ns/1ps
module sim_rtc_pi_core;
  logic       clk, rst_n, ref_tick;
  logic [3:0] rate_sel;
  logic [2:0] div_ctl;
  logic       ctl_set, ctl_pie, ctl_aie, ctl_uie, ctl_sqwe;
  logic       alarm_hit, upd_done, flag_rd;
  logic       sqw_out, irq_n, uip, upd_start;
  logic [7:0] flags;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  rtc_pi_core u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic read_flags();
    flag_rd = 1'b1; @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_tick = 1'b1; rate_sel = 4'd0; div_ctl = 3'b110;
    ctl_set = 0; ctl_pie = 0; ctl_aie = 0; ctl_uie = 0; ctl_sqwe = 0;
    alarm_hit = 0; upd_done = 0; flag_rd = 0;
    cyc(3); rst_n = 1'b1; cyc(3);
    check("R8 reset flags", flags, 0);
    check("R9 reset irq_n", irq_n, 1);
    check("R5 reset uip", uip, 0);
    check("R1 reset sqw", sqw_out, 0);
  endtask

  task automatic t_first_update();
    int n = 0;
    div_ctl = 3'b010;
    do begin @(negedge clk); n++; end while (!uip && n < 40000);
    check("R4 cycles to uip", n, 16376);
    n = 0;
    do begin @(negedge clk); n++; end while (!upd_start && n < 100);
    check("R5 uip lead", n, 8);
    upd_done = 1'b1; @(negedge clk); upd_done = 1'b0;
    check("R6 uip falls on done", uip, 0);
    check("R6 update flag", flags[4], 1);
    check("R9 no summary without enable", flags[7], 0);
    read_flags();
  endtask

  task automatic t_rate(input int r);
    int n = 0;
    rate_sel = 4'(r); ctl_sqwe = 1'b1;
    do begin @(negedge clk); n++; end while (sqw_out && n < 100000);
    do begin @(negedge clk); n++; end while (!sqw_out && n < 100000);
    n = 0;
    do begin @(negedge clk); n++; end while (sqw_out && n < 100000);
    do begin @(negedge clk); n++; end while (!sqw_out && n < 100000);
    check($sformatf("R2 sqw period rate %0d", r), n, 1 << r);
    check("R8 periodic flag", flags[6], 1);
  endtask

  task automatic t_sqwe_off();
    int hi = 0;
    rate_sel = 4'd3; ctl_sqwe = 1'b0;
    cyc(1); read_flags();
    for (int i = 0; i < 50; i++) begin @(negedge clk); if (sqw_out) hi++; end
    check("R3 sqw held low", hi, 0);
    check("R3 periodic flag still set", flags[6], 1);
    check("R9 irq_n without pie", irq_n, 1);
    ctl_pie = 1'b1; cyc(1);
    check("R9 irq with pie", irq_n, 0);
    ctl_pie = 1'b0;
  endtask

  task automatic t_rate0();
    int hi = 0, pf = 0;
    rate_sel = 4'd0; ctl_sqwe = 1'b1;
    cyc(1); read_flags();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (sqw_out) hi++; if (flags[6]) pf++;
    end
    check("R1 sqw off", hi, 0);
    check("R1 no periodic flag", pf, 0);
  endtask

  task automatic t_alarm();
    ctl_aie = 1'b0;
    alarm_hit = 1'b1; @(negedge clk); alarm_hit = 1'b0;
    check("R8 alarm flag bit5", flags[5], 1);
    check("R8 low nibble zero", flags[3:0], 0);
    check("R9 no summary", flags[7], 0);
    ctl_aie = 1'b1; cyc(1);
    check("R9 summary bit", flags[7], 1);
    check("R9 irq_n low", irq_n, 0);
    read_flags();
    check("R10 cleared", flags[5], 0);
    check("R10 irq released", irq_n, 1);
    alarm_hit = 1'b1; flag_rd = 1'b1; @(negedge clk);
    alarm_hit = 1'b0; flag_rd = 1'b0;
    check("R10 event kept over read", flags[5], 1);
    read_flags(); ctl_aie = 1'b0;
  endtask

  task automatic t_hold_and_timeout();
    int u = 0, s = 0, n = 0;
    ctl_set = 1'b1;
    for (int i = 0; i < 33000; i++) begin
      @(negedge clk); if (uip) u++; if (upd_start) s++;
    end
    check("R7 no uip while held", u, 0);
    check("R7 no start while held", s, 0);
    ctl_set = 1'b0;
    do begin @(negedge clk); n++; end while (!uip && n < 40000);
    n = 0;
    while (uip && n < 1000) begin @(negedge clk); n++; end
    check("R6 timeout window length", n, 73);
    check("R6 timeout sets flag", flags[4], 1);
  endtask

  initial begin
    t_reset();
    t_first_update();
    t_rate(1);
    t_rate(3);
    t_rate(6);
    t_sqwe_off();
    t_rate0();
    t_alarm();
    t_hold_and_timeout();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 190000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual 0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule